// File: doc/BRIEF.md
# Four-Channel Sample Register Bank with Alarm Sequencer

This block holds all the per-channel state of a four-input sampling front end in one 24-byte memory map. The map has three 8-byte pages: conversion results, per-channel control and status, and alarm thresholds. A host reaches the map through a plain byte port. Writes are taken on the clock edge and reads are combinational.

A conversion request names a set of channels and gives a 2-bit preset code for each one. The block first applies the presets to the selected result registers. It then asks an external sampler for one result at a time, in ascending channel order, over a request/done handshake. Each returned sample is trimmed to the channel's configured resolution and stored. The top byte of the stored result is then compared against the channel's two thresholds, and the alarm flags are updated.

From this state the block derives two outputs. One is a device-wide "take part in conditional search" flag. The other is a set of per-channel enables for open-drain pull-down transistors.

Top module: `qc_regbank`

## Requirements
- R1: Address `8*p + 2*c + b` selects page p, channel c (0 = A … 3 = D), byte b. Page 0 holds results (b=0 low byte, b=1 high byte). Page 1 holds control bytes. Page 2 holds thresholds (b=0 low, b=1 high). Any read at address 24 or above returns FFh.
- R2: After reset, every result reads 00h, every first control byte reads 08h, every second control byte reads 8Ch, every low threshold reads 00h and every high threshold reads FFh.
- R3: The first control byte of a channel is {oe, oc, 0, 0, res[3:0]}. Bits 5:4 always read 0.
- R4: The second control byte is {por, 0, hiFlag, loFlag, hiEn, loEn, 0, range}. Bits 6 and 1 always read 0. A host write can only clear hiFlag or loFlag (a written 0 clears the flag, a written 1 leaves it unchanged).
- R5: por is a single device-wide bit. A write to any channel's second control byte sets it to bit 7 of the written data, and every channel reads back the same value.
- R6: Writes to page 0, and to addresses 24 and above, change nothing.
- R7: A stored result is the sample ANDed with a mask that keeps the top N bits. N is 16 when res is 0, and N is res otherwise.
- R8: For each selected channel, in order A, B, C, D (unselected channels skipped), sampleReq rises with sampleChan naming that channel. Both are held until the cycle in which sampleDone is seen, and sampleReq is low in the next cycle.
- R9: When a conversion is accepted, each selected channel's result is preset according to bits [2c+1:2c] of convPreset. Code 00 leaves it unchanged, 01 clears it to 0000h, 10 sets it to FFFFh, and 11 leaves it unchanged. Unselected channels are never preset.
- R10: On storing a result, let T be the top byte of the stored result and M be the top byte of the resolution mask. hiFlag becomes T > (high threshold & M), and loFlag becomes T < (low threshold & M). A result with no alarm clears both flags.
- R11: condSearch is 1 whenever por is 1, or whenever some channel has (hiFlag and hiEn) or (loFlag and loEn).
- R12: pullDown[c] is 1 exactly when that channel's oe is 1 and its oc is 0.
- R13: busy rises in the cycle after an accepted convStart with a non-empty mask, and falls in the cycle after the last selected channel's sampleDone. A convStart while busy is ignored: it causes no presets and no extra channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Byte address into the map |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| convStart | input | 1 | Conversion request |
| convMask | input | 4 | Channel select mask, bit 0 = channel A |
| convPreset | input | 8 | Preset codes, 2 bits per channel |
| sampleReq | output | 1 | Request to the sampler |
| sampleChan | output | 2 | Channel being requested |
| sampleDone | input | 1 | Sampler has a result on sampleData |
| sampleData | input | 16 | Raw sample, MSB aligned |
| busy | output | 1 | Conversion sequence in progress |
| condSearch | output | 1 | Conditional-search participation flag |
| pullDown | output | 4 | Per-channel pull-down transistor enable |

## Verification
The bench aims at the resolution corners. Below eight bits, the threshold's low bits must be masked; a design that compared the raw threshold would raise false low alarms, for example a sample of 1000h at res 4 against a low threshold of 1Fh. It also exercises illegal preset code 11 and presets on unselected channels; a design that decoded these wrongly would overwrite results it should leave alone. A convStart during busy and a write of 1 to an alarm flag are both applied: the first would add channels or presets if not ignored, and the second would raise a spurious condSearch. Writes to page 0 and out-of-map addresses are followed by a full map readback, and the sampler's done is delayed at random, so any corruption or loss of the held channel number shows at the ports.

// File: rtl/qc_pkg.sv
package qc_pkg;
  localparam int NUM_CH     = 4;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int RES_W      = 16;
  localparam int PAGE_BYTES = 2 * NUM_CH;
  localparam int MAP_BYTES  = 3 * PAGE_BYTES;
  localparam int ADDR_W     = 8;

  typedef struct packed {
    logic              doPreset;
    logic [NUM_CH-1:0] presetSel;
    logic              doStore;
    logic [CH_W-1:0]   storeChan;
  } qcStrobe_t;

  // keep the top N bits of a result; code 0 means full width
  function automatic logic [RES_W-1:0] resMask(input logic [3:0] code);
    logic [RES_W-1:0] ones;
    int unsigned n;
    ones = '1;
    n = (code == 4'd0) ? RES_W : int'(code);
    return ~(ones >> n);
  endfunction
endpackage

// File: rtl/qc_control.sv
module qc_control
  import qc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic [NUM_CH-1:0] convMask,
  input  logic              sampleDone,
  output logic              sampleReq,
  output logic [CH_W-1:0]   sampleChan,
  output logic              busy,
  output qcStrobe_t         strobe
);
  logic [NUM_CH-1:0] pending;
  logic              reqActive;
  logic [CH_W-1:0]   chanQ;
  logic [CH_W-1:0]   nextChan;
  logic              accept;

  // lowest pending channel wins
  always_comb begin
    nextChan = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) nextChan = CH_W'(i);
    end
  end

  assign accept = convStart && (pending == '0) && !reqActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= '0;
      reqActive <= 1'b0;
      chanQ     <= '0;
    end else if (accept) begin
      pending <= convMask;
    end else if (reqActive) begin
      if (sampleDone) begin
        pending[chanQ] <= 1'b0;
        reqActive      <= 1'b0;
      end
    end else if (pending != '0) begin
      reqActive <= 1'b1;
      chanQ     <= nextChan;
    end
  end

  always_comb begin
    strobe.doPreset  = accept;
    strobe.presetSel = convMask;
    strobe.doStore   = reqActive && sampleDone;
    strobe.storeChan = chanQ;
  end

  assign sampleReq  = reqActive;
  assign sampleChan = chanQ;
  assign busy       = |pending;
endmodule

// File: rtl/qc_datapath.sv
module qc_datapath
  import qc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  qcStrobe_t           strobe,
  input  logic [2*NUM_CH-1:0] convPreset,
  input  logic [RES_W-1:0]    sampleData,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  output logic                condSearch,
  output logic [NUM_CH-1:0]   pullDown,
  output logic                porFlag
);
  logic [NUM_CH-1:0][RES_W-1:0] result;
  logic [NUM_CH-1:0][3:0]       rc;
  logic [NUM_CH-1:0][7:0]       thrLo, thrHi;
  logic [NUM_CH-1:0]            oe, oc, afh, afl, aeh, ael, ir;
  logic [NUM_CH-1:0]            hiHit, loHit;
  logic                         por;

  logic            inMap, odd, wrCtl, wrThr;
  logic [1:0]      page;
  logic [CH_W-1:0] ch;

  assign inMap = regAddr < ADDR_W'(MAP_BYTES);
  assign page  = regAddr[4:3];
  assign ch    = regAddr[CH_W:1];
  assign odd   = regAddr[0];
  assign wrCtl = regWrEn && inMap && (page == 2'd1);
  assign wrThr = regWrEn && inMap && (page == 2'd2);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic [RES_W-1:0] m;
      logic [7:0]       tm, top;
      assign m           = resMask(rc[g]);
      assign tm          = m[RES_W-1 -: 8];
      assign top         = sampleData[RES_W-1 -: 8] & tm;
      assign hiHit[g]    = top > (thrHi[g] & tm);
      assign loHit[g]    = top < (thrLo[g] & tm);
      assign pullDown[g] = oe[g] & ~oc[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      por <= 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
        result[i] <= '0;
        rc[i]     <= 4'd8;
        thrLo[i]  <= 8'h00;
        thrHi[i]  <= 8'hFF;
        oe[i]     <= 1'b0;
        oc[i]     <= 1'b0;
        afh[i]    <= 1'b0;
        afl[i]    <= 1'b0;
        aeh[i]    <= 1'b1;
        ael[i]    <= 1'b1;
        ir[i]     <= 1'b0;
      end
    end else begin
      if (wrCtl && odd) por <= regWrData[7];
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrCtl && ch == CH_W'(i)) begin
          if (!odd) begin
            oe[i] <= regWrData[7];
            oc[i] <= regWrData[6];
            rc[i] <= regWrData[3:0];
          end else begin
            aeh[i] <= regWrData[3];
            ael[i] <= regWrData[2];
            ir[i]  <= regWrData[0];
          end
        end
        if (wrThr && ch == CH_W'(i)) begin
          if (odd) thrHi[i] <= regWrData;
          else     thrLo[i] <= regWrData;
        end
        if (strobe.doStore && strobe.storeChan == CH_W'(i)) begin
          result[i] <= sampleData & resMask(rc[i]);
          afh[i]    <= hiHit[i];
          afl[i]    <= loHit[i];
        end else begin
          if (strobe.doPreset && strobe.presetSel[i]) begin
            case (convPreset[2*i +: 2])
              2'b01:   result[i] <= '0;
              2'b10:   result[i] <= '1;
              default: ;
            endcase
          end
          if (wrCtl && odd && ch == CH_W'(i)) begin
            afh[i] <= afh[i] & regWrData[5];
            afl[i] <= afl[i] & regWrData[4];
          end
        end
      end
    end
  end

  always_comb begin
    regRdData = 8'hFF;
    if (inMap) begin
      case (page)
        2'd0: regRdData = odd ? result[ch][RES_W-1 -: 8] : result[ch][7:0];
        2'd1: regRdData = odd ? {por, 1'b0, afh[ch], afl[ch], aeh[ch], ael[ch], 1'b0, ir[ch]}
                              : {oe[ch], oc[ch], 2'b00, rc[ch]};
        2'd2: regRdData = odd ? thrHi[ch] : thrLo[ch];
        default: regRdData = 8'hFF;
      endcase
    end
  end

  assign condSearch = por | (|((afh & aeh) | (afl & ael)));
  assign porFlag    = por;
endmodule

// File: rtl/qc_regbank.sv
module qc_regbank
  import qc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [7:0]          regWrData,
  output logic [7:0]          regRdData,
  input  logic                convStart,
  input  logic [NUM_CH-1:0]   convMask,
  input  logic [2*NUM_CH-1:0] convPreset,
  output logic                sampleReq,
  output logic [CH_W-1:0]     sampleChan,
  input  logic                sampleDone,
  input  logic [RES_W-1:0]    sampleData,
  output logic                busy,
  output logic                condSearch,
  output logic [NUM_CH-1:0]   pullDown
);
  qcStrobe_t strobe;
  logic      porFlag;

  qc_control u_ctrl (
    .clk(clk), .rstN(rstN), .convStart(convStart), .convMask(convMask),
    .sampleDone(sampleDone), .sampleReq(sampleReq), .sampleChan(sampleChan),
    .busy(busy), .strobe(strobe)
  );

  qc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convPreset(convPreset),
    .sampleData(sampleData), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .condSearch(condSearch),
    .pullDown(pullDown), .porFlag(porFlag)
  );
endmodule

// File: rtl/qc_regbank_chk.sv
module qc_regbank_chk
  import qc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regRdData,
  input logic              sampleReq,
  input logic [CH_W-1:0]   sampleChan,
  input logic              sampleDone,
  input logic              busy,
  input logic              condSearch,
  input logic              porFlag
);
  a_r8_req_within_busy: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |-> busy);

  a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReq && !sampleDone) |=> (sampleReq && $stable(sampleChan)));

  a_r8_drop_after_done: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReq && sampleDone) |=> !sampleReq);

  a_r1_outside_map: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_W'(MAP_BYTES)) |-> (regRdData == 8'hFF));

  a_r11_por_forces_search: assert property (@(posedge clk) disable iff (!rstN)
    porFlag |-> condSearch);
endmodule

bind qc_regbank qc_regbank_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .sampleReq(sampleReq), .sampleChan(sampleChan), .sampleDone(sampleDone),
  .busy(busy), .condSearch(condSearch), .porFlag(porFlag)
);

// File: tb/qc_regbank_test.sv
module qc_regbank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        convStart = 1'b0;
  logic [3:0]  convMask = '0;
  logic [7:0]  convPreset = '0;
  logic        sampleReq;
  logic [1:0]  sampleChan;
  logic        sampleDone = 1'b0;
  logic [15:0] sampleData = '0;
  logic        busy, condSearch;
  logic [3:0]  pullDown;

  always #4 clk = ~clk;  // 125 MHz

  qc_regbank uut (.*);

  int compared = 0, mismatched = 0;
  bit timedOut = 0;

  // reference model
  logic [15:0] mRes[4];
  logic [3:0]  mRc[4];
  logic [7:0]  mLo[4], mHi[4];
  bit mOe[4], mOc[4], mAfh[4], mAfl[4], mAeh[4], mAel[4], mIr[4];
  bit mPor;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] maskOf(logic [3:0] code);
    int n = (code == 0) ? 16 : int'(code);
    logic [15:0] m = '0;
    for (int b = 0; b < n; b++) m[15-b] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] expRd(int a);
    int c = (a % 8) / 2;
    bit o = a[0];
    if (a >= 24) return 8'hFF;
    if (a < 8)  return o ? mRes[c][15:8] : mRes[c][7:0];
    if (a < 16) return o ? {mPor, 1'b0, mAfh[c], mAfl[c], mAeh[c], mAel[c], 1'b0, mIr[c]}
                         : {mOe[c], mOc[c], 2'b00, mRc[c]};
    return o ? mHi[c] : mLo[c];
  endfunction

  function automatic bit expCs();
    bit r = mPor;
    for (int c = 0; c < 4; c++) r |= (mAfh[c] & mAeh[c]) | (mAfl[c] & mAel[c]);
    return r;
  endfunction

  task automatic modelReset();
    mPor = 1;
    for (int c = 0; c < 4; c++) begin
      mRes[c] = 0; mRc[c] = 8; mLo[c] = 0; mHi[c] = 8'hFF;
      mOe[c] = 0; mOc[c] = 0; mAfh[c] = 0; mAfl[c] = 0;
      mAeh[c] = 1; mAel[c] = 1; mIr[c] = 0;
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    regAddr = 8'(a); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a >= 8 && a < 16) begin
      int c = (a - 8) / 2;
      if (!a[0]) begin mOe[c] = d[7]; mOc[c] = d[6]; mRc[c] = d[3:0]; end
      else begin
        mPor = d[7]; mAfh[c] &= d[5]; mAfl[c] &= d[4];
        mAeh[c] = d[3]; mAel[c] = d[2]; mIr[c] = d[0];
      end
    end else if (a >= 16 && a < 24) begin
      int c = (a - 16) / 2;
      if (a[0]) mHi[c] = d; else mLo[c] = d;
    end
  endtask

  task automatic rdChk(int a, string tag);
    @(negedge clk);
    regAddr = 8'(a);
    #1;
    chk($sformatf("%s addr %0d", tag, a), regRdData, expRd(a));
  endtask

  task automatic checkAll(string tag);
    for (int a = 0; a < 24; a++) rdChk(a, tag);
    rdChk(24, "R1 outside");
    rdChk(31, "R1 outside");
    rdChk(200, "R1 outside");
    begin
      logic [3:0] pd;
      for (int c = 0; c < 4; c++) pd[c] = mOe[c] & ~mOc[c];
      chk({tag, " R12 pullDown"}, pullDown, pd);
    end
    chk({tag, " R11 condSearch"}, condSearch, expCs());
  endtask

  // one conversion; data per channel from dv, optional ignored restart
  task automatic convert(logic [3:0] mask, logic [7:0] pre, logic [15:0] dv[4], bit poke);
    for (int c = 0; c < 4; c++) begin
      if (mask[c]) begin
        if (pre[2*c +: 2] == 2'b01) mRes[c] = 16'h0000;
        else if (pre[2*c +: 2] == 2'b10) mRes[c] = 16'hFFFF;
      end
    end
    @(negedge clk);
    convStart = 1'b1; convMask = mask; convPreset = pre;
    @(negedge clk);
    convStart = 1'b0;
    chk("R13 busy after start", busy, (mask != 0));
    for (int a = 0; a < 8; a++) rdChk(a, "R9 preset");
    if (poke && mask != 0) begin
      @(negedge clk);
      convStart = 1'b1; convMask = 4'hF; convPreset = 8'h55;
      @(negedge clk);
      convStart = 1'b0;
    end
    for (int c = 0; c < 4; c++) begin
      if (mask[c]) begin
        int cnt = 0;
        while (!sampleReq && cnt < 20) begin @(negedge clk); cnt++; end
        chk("R8 request seen", sampleReq, 1);
        chk("R8 channel order", sampleChan, c);
        repeat ($urandom_range(0, 3)) begin
          @(negedge clk);
          chk("R8 held channel", {sampleReq, sampleChan}, {1'b1, 2'(c)});
        end
        sampleData = dv[c]; sampleDone = 1'b1;
        @(negedge clk);
        sampleDone = 1'b0;
        chk("R8 req dropped", sampleReq, 0);
        begin
          logic [15:0] m = maskOf(mRc[c]);
          logic [7:0] t;
          mRes[c] = dv[c] & m;
          t = mRes[c][15:8];
          mAfh[c] = t > (mHi[c] & m[15:8]);
          mAfl[c] = t < (mLo[c] & m[15:8]);
        end
      end
    end
    @(negedge clk);
    chk("R13 busy cleared", busy, 0);
  endtask

  task automatic runAll();
    logic [15:0] dv[4];
    void'($urandom(32'd2718));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R2 reset");

    wr(3, 8'h55); wr(6, 8'hAA);
    checkAll("R6 page0 write");
    wr(30, 8'h00);
    checkAll("R6 outside write");

    wr(8, 8'hFF);
    rdChk(8, "R3 ctl0 zero bits");
    wr(9, 8'hFF);
    rdChk(9, "R4 ctl1 zero bits");
    wr(12, 8'h0C);
    checkAll("R5 por shared");

    // channel D: res 12, thresholds 64h/96h, high alarm
    wr(14, 8'h0C); wr(15, 8'h0C); wr(22, 8'h64); wr(23, 8'h96);
    dv = '{16'h0, 16'h0, 16'h0, 16'hA7F3};
    convert(4'b1000, 8'h80, dv, 0);
    checkAll("R10 high alarm R7 trim");
    wr(15, 8'h3C);
    checkAll("R4 write one keeps flag");
    wr(15, 8'h0C);
    checkAll("R4 write zero clears flag");

    // channel B: res 4, low threshold 1Fh masked to 10h -> no alarm
    wr(10, 8'h04); wr(11, 8'h0C); wr(18, 8'h1F); wr(19, 8'hFF);
    dv = '{16'h0, 16'h1234, 16'h0, 16'h0};
    convert(4'b0010, 8'h04, dv, 0);
    checkAll("R10 low res threshold mask");
    dv = '{16'h0, 16'h0FFF, 16'h0, 16'h0};
    convert(4'b0010, 8'h08, dv, 0);
    checkAll("R10 low alarm");

    // illegal preset and unselected presets; restart while busy ignored
    dv = '{16'hFFFF, 16'h0, 16'h8001, 16'h0};
    convert(4'b0101, 8'hAB, dv, 1);
    checkAll("R13 restart ignored R9 code 11");
    dv = '{16'h0, 16'h0, 16'h0, 16'h0};
    convert(4'b0000, 8'h55, dv, 0);
    checkAll("R13 empty mask");
    convert(4'b1111, 8'h00, dv, 0);
    checkAll("R10 zero sample");

    for (int it = 0; it < 30; it++) begin
      for (int w = 0; w < 3; w++) wr($urandom_range(0, 31), 8'($urandom));
      for (int c = 0; c < 4; c++) dv[c] = 16'($urandom);
      convert(4'($urandom), 8'($urandom), dv, bit'($urandom_range(0, 1)));
      checkAll("R7 R10 random");
    end
  endtask

  initial begin
    fork
      runAll();
      begin repeat (150000) @(posedge clk); timedOut = 1; end
    join_any
    disable fork;
    if (timedOut) begin
      compared++; mismatched++;
      $display("FAIL R13 watchdog act=hung exp=finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule